// File: doc/BRIEF.md
# Processor Bus to USB FIFO Bridge

This block connects an asynchronous 8-bit processor memory bus to a parallel USB FIFO module. A bus access is taken only when the active-low chip select and the active-low byte-0 enable are both low. Its 7-bit word address then selects one of three targets. Word 0 is the USB data port, which can be read and written. Word 1 is a read-only status byte that shows the FIFO handshake pins and some board pins. Word 2 is a read/write test register, which software uses to check that the board is fitted.

FIFO read and write strobes are combinational copies of the bus strobes. Read data is therefore valid inside the bus read strobe, and write data is held on the FIFO data lines for the whole bus write strobe. The receive-data-available flag from the FIFO is synchronized to the logic clock. A falling edge of that flag produces a one-clock interrupt pulse. Software polls the status byte before each transfer, so the bridge does not block a write when the FIFO reports that it is busy.

Top module: `usb_bus_bridge`

## Requirements
- R1: A bus read of word 0 (chip select, byte enable and read strobe all low) drives `fifo_rd_no` low for exactly the time the read strobe is low. During that time `bus_data_o` equals `fifo_data_i` and `bus_data_oe_o` is 1.
- R2: A bus write to word 0 drives `fifo_wr_no` low for exactly the time the write strobe is low. During that time `fifo_data_o` equals `bus_data_i` and `fifo_data_oe_o` is 1.
- R3: A read of word 1 returns the status byte. Bit 7 is `rst_out_i`, bit 6 is `vcc_out_i`, bit 5 is `board_id_i`, bits 4 and 3 are 0, bit 2 is `sleep_i`, bit 1 is `fifo_rxf_ni` and bit 0 is `fifo_txe_ni`, each as seen at its pin.
- R4: The status byte is read-only. A write to word 1 changes no later read of word 1, word 2 or word 0.
- R5: A write to word 2 stores the bus byte. A later read of word 2 returns that byte unchanged, for example 0xAB or 0x54. The stored byte resets to 0x00.
- R6: While chip select or byte enable 0 is high, both FIFO strobes stay high, `fifo_data_oe_o` and `bus_data_oe_o` stay 0, and the test register keeps its value.
- R7: A read of a word address above 2 returns 0x00 with `bus_data_oe_o` set. A write to such an address changes nothing.
- R8: `bus_data_oe_o` is 1 only during a selected read. At all other times `bus_data_o` is 0x00.
- R9: Each 1-to-0 transition of `fifo_rxf_ni` produces exactly one `irq_o` pulse one clock long. The pulse is high after the SYNC_STAGES-th rising edge that follows the change. A 0-to-1 transition produces no pulse.
- R10: Accesses to word 1 or word 2 never pulse a FIFO strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Logic clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 7 | Bus word address |
| bus_cs_ni | input | 1 | Chip select, active low |
| bus_be0_ni | input | 1 | Byte-0 enable, active low |
| bus_rd_ni | input | 1 | Bus read strobe, active low |
| bus_wr_ni | input | 1 | Bus write strobe, active low |
| bus_data_i | input | 8 | Bus write data |
| bus_data_o | output | 8 | Bus read data, 0 when not driven |
| bus_data_oe_o | output | 1 | Bus read data enable |
| fifo_rd_no | output | 1 | FIFO read strobe, active low |
| fifo_wr_no | output | 1 | FIFO write strobe, active low |
| fifo_data_i | input | 8 | FIFO read data |
| fifo_data_o | output | 8 | FIFO write data |
| fifo_data_oe_o | output | 1 | FIFO write data enable |
| fifo_rxf_ni | input | 1 | Receive data waiting, active low |
| fifo_txe_ni | input | 1 | Transmit space available, active low (1 means busy or full) |
| rst_out_i | input | 1 | Board pin reported in status bit 7 |
| vcc_out_i | input | 1 | Board pin reported in status bit 6 |
| board_id_i | input | 1 | Board pin reported in status bit 5 |
| sleep_i | input | 1 | Board pin reported in status bit 2 |
| irq_o | output | 1 | Receive interrupt pulse |

## Verification
The strobe, data-enable and read-mux outputs are combinational, so they are due in the same time step as the bus inputs. The bench samples them in the middle of each strobe, well away from any clock edge. Test register writes land on the first rising edge inside the write strobe, so the bench checks them only through a later read. The interrupt follows the SYNC_STAGES synchronizer flops. The bench changes the receive flag on a falling edge, counts rising edges, and expects the single pulse after the second of them.

// File: rtl/usb_bridge_pkg.sv
package usb_bridge_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_USB  = 2'd1,
    TGT_STAT = 2'd2,
    TGT_TEST = 2'd3
  } tgt_e;

  localparam logic [ADDR_W-1:0] WORD_USB  = 7'd0;
  localparam logic [ADDR_W-1:0] WORD_STAT = 7'd1;
  localparam logic [ADDR_W-1:0] WORD_TEST = 7'd2;
endpackage

// File: rtl/bridge_decode.sv
module bridge_decode
  import usb_bridge_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cs_ni,
  input  logic              be0_ni,
  output logic              acc_o,
  output tgt_e              tgt_o
);
  assign acc_o = ~cs_ni & ~be0_ni;

  always_comb begin
    tgt_o = TGT_NONE;
    if (acc_o) begin
      unique case (addr_i)
        WORD_USB:  tgt_o = TGT_USB;
        WORD_STAT: tgt_o = TGT_STAT;
        WORD_TEST: tgt_o = TGT_TEST;
        default:   tgt_o = TGT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/bridge_fifo_strobe.sv
module bridge_fifo_strobe #(
  parameter int unsigned DW = 8
) (
  input  logic          usb_sel_i,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic [DW-1:0] wdata_i,
  output logic          fifo_rd_no,
  output logic          fifo_wr_no,
  output logic [DW-1:0] fifo_wdata_o,
  output logic          fifo_wdata_oe_o
);
  logic wr_act;
  // strobes pass straight through: no clock in the path
  assign fifo_rd_no      = ~(usb_sel_i & ~rd_ni);
  assign wr_act          = usb_sel_i & ~wr_ni;
  assign fifo_wr_no      = ~wr_act;
  assign fifo_wdata_oe_o = wr_act;
  assign fifo_wdata_o    = wr_act ? wdata_i : '0;
endmodule

// File: rtl/bridge_rx_irq.sv
module bridge_rx_irq #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rxf_ni,
  output logic irq_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], rxf_ni};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  // pulse while the synchronized flag is low and was high one cycle earlier
  assign irq_o = last_q & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/bridge_test_reg.sv
module bridge_test_reg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/usb_bus_bridge.sv
module usb_bus_bridge
  import usb_bridge_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_cs_ni,
  input  logic              bus_be0_ni,
  input  logic              bus_rd_ni,
  input  logic              bus_wr_ni,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_data_oe_o,
  output logic              fifo_rd_no,
  output logic              fifo_wr_no,
  input  logic [DATA_W-1:0] fifo_data_i,
  output logic [DATA_W-1:0] fifo_data_o,
  output logic              fifo_data_oe_o,
  input  logic              fifo_rxf_ni,
  input  logic              fifo_txe_ni,
  input  logic              rst_out_i,
  input  logic              vcc_out_i,
  input  logic              board_id_i,
  input  logic              sleep_i,
  output logic              irq_o
);
  logic              acc;
  tgt_e              tgt;
  logic [DATA_W-1:0] test_q;
  logic [DATA_W-1:0] stat_byte;
  logic              rd_act;

  bridge_decode i_decode (
    .addr_i (bus_addr_i),
    .cs_ni  (bus_cs_ni),
    .be0_ni (bus_be0_ni),
    .acc_o  (acc),
    .tgt_o  (tgt)
  );

  bridge_fifo_strobe #(.DW(DATA_W)) i_strobe (
    .usb_sel_i       (tgt == TGT_USB),
    .rd_ni           (bus_rd_ni),
    .wr_ni           (bus_wr_ni),
    .wdata_i         (bus_data_i),
    .fifo_rd_no      (fifo_rd_no),
    .fifo_wr_no      (fifo_wr_no),
    .fifo_wdata_o    (fifo_data_o),
    .fifo_wdata_oe_o (fifo_data_oe_o)
  );

  // bus write strobe spans several clocks; each edge inside it reloads the same byte
  bridge_test_reg #(.DW(DATA_W)) i_test_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    ((tgt == TGT_TEST) & ~bus_wr_ni),
    .wdata_i (bus_data_i),
    .q_o     (test_q)
  );

  bridge_rx_irq #(.SYNC_STAGES(SYNC_STAGES)) i_rx_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rxf_ni (fifo_rxf_ni),
    .irq_o  (irq_o)
  );

  assign stat_byte = {rst_out_i, vcc_out_i, board_id_i, 2'b00,
                      sleep_i, fifo_rxf_ni, fifo_txe_ni};

  assign rd_act        = acc & ~bus_rd_ni;
  assign bus_data_oe_o = rd_act;

  always_comb begin
    bus_data_o = '0;
    if (rd_act) begin
      unique case (tgt)
        TGT_USB:  bus_data_o = fifo_data_i;
        TGT_STAT: bus_data_o = stat_byte;
        TGT_TEST: bus_data_o = test_q;
        default:  bus_data_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/usb_bus_bridge_chk.sv
module usb_bus_bridge_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [6:0] bus_addr_i,
  input logic       bus_cs_ni,
  input logic       bus_be0_ni,
  input logic       bus_rd_ni,
  input logic       bus_wr_ni,
  input logic [7:0] bus_data_i,
  input logic [7:0] bus_data_o,
  input logic       bus_data_oe_o,
  input logic       fifo_rd_no,
  input logic       fifo_wr_no,
  input logic [7:0] fifo_data_o,
  input logic       fifo_data_oe_o,
  input logic       irq_o
);
  a_r6_quiet_unselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cs_ni || bus_be0_ni) |-> (fifo_rd_no && fifo_wr_no && !bus_data_oe_o && !fifo_data_oe_o));

  a_r1_rd_strobe_addr0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_rd_no |-> (!bus_rd_ni && bus_addr_i == 7'd0 && bus_data_oe_o));

  a_r2_wr_data_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_wr_no |-> (fifo_data_oe_o && fifo_data_o == bus_data_i && bus_addr_i == 7'd0));

  a_r8_oe_only_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_data_oe_o |-> (bus_data_o == 8'h00));

  a_r9_irq_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
endmodule

bind usb_bus_bridge usb_bus_bridge_chk i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .bus_addr_i     (bus_addr_i),
  .bus_cs_ni      (bus_cs_ni),
  .bus_be0_ni     (bus_be0_ni),
  .bus_rd_ni      (bus_rd_ni),
  .bus_wr_ni      (bus_wr_ni),
  .bus_data_i     (bus_data_i),
  .bus_data_o     (bus_data_o),
  .bus_data_oe_o  (bus_data_oe_o),
  .fifo_rd_no     (fifo_rd_no),
  .fifo_wr_no     (fifo_wr_no),
  .fifo_data_o    (fifo_data_o),
  .fifo_data_oe_o (fifo_data_oe_o),
  .irq_o          (irq_o)
);

// File: tb/test_usb_bus_bridge.sv
`timescale 1ns/1ps
module test_usb_bus_bridge;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] addr = '0;
  logic       cs_n = 1'b1, be0_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rdata_oe;
  logic       frd_n, fwr_n;
  logic [7:0] fifo_rdata = 8'h00;
  logic [7:0] fifo_wdata;
  logic       fifo_wdata_oe;
  logic       rxf_n = 1'b1, txe_n = 1'b0;
  logic       p_rst = 1'b0, p_vcc = 1'b0, p_id = 1'b0, p_sleep = 1'b0;
  logic       irq;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  usb_bus_bridge i_usb_bus_bridge (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_cs_ni(cs_n),
    .bus_be0_ni(be0_n), .bus_rd_ni(rd_n), .bus_wr_ni(wr_n),
    .bus_data_i(wdata), .bus_data_o(rdata), .bus_data_oe_o(rdata_oe),
    .fifo_rd_no(frd_n), .fifo_wr_no(fwr_n), .fifo_data_i(fifo_rdata),
    .fifo_data_o(fifo_wdata), .fifo_data_oe_o(fifo_wdata_oe),
    .fifo_rxf_ni(rxf_n), .fifo_txe_ni(txe_n), .rst_out_i(p_rst),
    .vcc_out_i(p_vcc), .board_id_i(p_id), .sleep_i(p_sleep), .irq_o(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // setup 30, strobe 110, hold 30; outputs sampled mid-strobe
  task automatic bus_read(input logic [6:0] a, input logic sel,
                          output logic [7:0] d, output logic oe, output logic rs);
    addr = a; cs_n = ~sel; be0_n = ~sel;
    #30 rd_n = 1'b0;
    #55 d = rdata; oe = rdata_oe; rs = frd_n;
    #55 rd_n = 1'b1;
    #30 cs_n = 1'b1; be0_n = 1'b1;
  endtask

  // setup 30, strobe 80, hold 30
  task automatic bus_write(input logic [6:0] a, input logic [7:0] v, input logic sel,
                           output logic ws, output logic [7:0] fd, output logic foe);
    addr = a; wdata = v; cs_n = ~sel; be0_n = ~sel;
    #30 wr_n = 1'b0;
    #40 ws = fwr_n; fd = fifo_wdata; foe = fifo_wdata_oe;
    #40 wr_n = 1'b1;
    #30 cs_n = 1'b1; be0_n = 1'b1;
  endtask

  task automatic t_reset;
    logic [7:0] d; logic oe, rs;
    check("R5 reset strobes", {frd_n, fwr_n, irq, rdata_oe}, 4'b1100);
    bus_read(7'd2, 1'b1, d, oe, rs);
    check("R5 test reg reset value", d, 8'h00);
  endtask

  task automatic t_usb_port;
    logic [7:0] d, fd; logic oe, rs, ws, foe;
    fifo_rdata = 8'h3C;
    bus_read(7'd0, 1'b1, d, oe, rs);
    check("R1 read data/oe/strobe", {d, oe, rs}, {8'h3C, 1'b1, 1'b0});
    check("R1 strobe released", frd_n, 1'b1);
    fifo_rdata = 8'hC5;
    bus_read(7'd0, 1'b1, d, oe, rs);
    check("R1 second byte", d, 8'hC5);
    bus_write(7'd0, 8'h96, 1'b1, ws, fd, foe);
    check("R2 write strobe/data/oe", {ws, fd, foe}, {1'b0, 8'h96, 1'b1});
    check("R2 write strobe released", {fwr_n, fifo_wdata_oe}, 2'b10);
  endtask

  task automatic t_status;
    logic [7:0] d, fd; logic oe, rs, ws, foe;
    p_rst = 1; p_vcc = 0; p_id = 1; p_sleep = 0; rxf_n = 1; txe_n = 0;
    bus_read(7'd1, 1'b1, d, oe, rs);
    check("R3 status pattern A", d, 8'b1010_0010);
    check("R10 no fifo read on status", rs, 1'b1);
    p_rst = 0; p_vcc = 1; p_id = 0; p_sleep = 1; txe_n = 1;
    bus_read(7'd1, 1'b1, d, oe, rs);
    check("R3 status pattern B", d, 8'b0100_0111);
    bus_write(7'd1, 8'hFF, 1'b1, ws, fd, foe);
    check("R4 R10 write to status no strobe", {ws, foe}, 2'b10);
    bus_read(7'd1, 1'b1, d, oe, rs);
    check("R4 status unchanged", d, 8'b0100_0111);
    bus_read(7'd2, 1'b1, d, oe, rs);
    check("R4 test reg unchanged", d, 8'h00);
    p_sleep = 0; txe_n = 0;
  endtask

  task automatic t_test_reg;
    logic [7:0] d, fd; logic oe, rs, ws, foe;
    bus_write(7'd2, 8'hAB, 1'b1, ws, fd, foe);
    check("R10 test write no strobe", {ws, foe}, 2'b10);
    bus_read(7'd2, 1'b1, d, oe, rs);
    check("R5 readback 0xAB", {d, rs}, {8'hAB, 1'b1});
    bus_write(7'd2, 8'h54, 1'b1, ws, fd, foe);
    bus_read(7'd2, 1'b1, d, oe, rs);
    check("R5 readback 0x54", d, 8'h54);
  endtask

  task automatic t_unselected;
    logic [7:0] d, fd; logic oe, rs, ws, foe;
    fifo_rdata = 8'h77;
    bus_read(7'd0, 1'b0, d, oe, rs);
    check("R6 R8 read unselected", {d, oe, rs}, {8'h00, 1'b0, 1'b1});
    bus_write(7'd2, 8'h11, 1'b0, ws, fd, foe);
    check("R6 write unselected", {ws, foe}, 2'b10);
    addr = 7'd0; wdata = 8'h22; cs_n = 1'b0; be0_n = 1'b1;
    #30 wr_n = 1'b0;
    #40 check("R6 byte enable high", {fwr_n, fifo_wdata_oe}, 2'b10);
    #40 wr_n = 1'b1;
    #30 cs_n = 1'b1;
    bus_read(7'd2, 1'b1, d, oe, rs);
    check("R6 test reg kept", d, 8'h54);
    check("R8 idle bus", {rdata, rdata_oe}, 9'h000);
  endtask

  task automatic t_unmapped;
    logic [7:0] d, fd; logic oe, rs, ws, foe;
    bus_read(7'd3, 1'b1, d, oe, rs);
    check("R7 read word 3", {d, oe, rs}, {8'h00, 1'b1, 1'b1});
    bus_read(7'd127, 1'b1, d, oe, rs);
    check("R7 read word 127", {d, oe}, {8'h00, 1'b1});
    bus_write(7'd6, 8'hEE, 1'b1, ws, fd, foe);
    check("R7 write unmapped no strobe", {ws, foe}, 2'b10);
    bus_read(7'd2, 1'b1, d, oe, rs);
    check("R7 test reg kept", d, 8'h54);
  endtask

  task automatic t_irq;
    int first = 0, pulses = 0;
    @(negedge clk) rxf_n = 1'b0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (irq) begin
        pulses++;
        if (first == 0) first = i;
      end
    end
    check("R9 fall pulse count", pulses, 1);
    check("R9 fall pulse cycle", first, 2);
    pulses = 0;
    @(negedge clk) rxf_n = 1'b1;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (irq) pulses++;
    end
    check("R9 no pulse on rise", pulses, 0);
    pulses = 0;
    @(negedge clk) rxf_n = 1'b0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (irq) pulses++;
    end
    check("R9 second fall pulse", pulses, 1);
    rxf_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #5000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_usb_port();
    t_status();
    t_test_reg();
    t_unselected();
    t_unmapped();
    t_irq();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule